// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two tri-state buses, A and B, of a configurable width. Each transfer direction owns a capture register and a source choice, so the bus it drives carries either the live level of the opposite bus or a value captured earlier. The A-to-B path drives B when its enable is high. The B-to-A path drives A when its enable is low. A polarity parameter makes every value the block drives onto a bus the complement of its source.

All sequential state runs on one system clock. The two capture strobes are sampled on that clock, and a register loads on the first clock edge at which its strobe is seen high after being low. Capture does not depend on any enable or select. When both directions are enabled in live mode, the two paths would form a loop through the buses. Two keeper registers break that loop. Each keeper follows its own bus level until the loop mode is entered, and from then on each bus is driven with its last level.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both capture registers, both keepers and the strobe history. Right after reset, a bus that is driven from stored data shows all zeros, or all ones when `INVERT`=1.
- R2: B is driven only while `oe_ab`=1, and A is driven only while `oe_ba_n`=0. While a bus is not driven, the level an external driver places on it is what appears on that bus.
- R3: A select at 0 routes the live level of the opposite bus to the driven bus in the same cycle, with no clock edge needed.
- R4: A select at 1 routes that direction's capture register to the driven bus: `sel_ab` selects for B and `sel_ba` selects for A. While no capture fires, that value does not change.
- R5: At a clock edge where `cap_ab` (or `cap_ba`) is 1 and was 0 at the previous edge, the A-to-B register loads the A bus level (the B-to-A register loads the B bus level). This happens for every combination of enables and selects.
- R6: A strobe held high over further edges does not load the register again, and a strobe at 0 never loads it.
- R7: With both directions enabled and both selects at 1, A shows the B-to-A register and B shows the A-to-B register, each through the polarity.
- R8: With both directions enabled and both selects at 0, and no external drivers, each bus keeps the level it had at the last clock edge before this mode was entered, for both polarity settings.
- R9: With `INVERT`=1, every live or stored value driven onto a bus is the bitwise complement of the same value with `INVERT`=0.
- R10: When a bus shows stored data, the value captured at a clock edge is on that bus from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for capture, strobe history and keepers |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab | input | 1 | Capture strobe for the A-to-B register (rising level loads A) |
| cap_ba | input | 1 | Capture strobe for the B-to-A register (rising level loads B) |
| oe_ab | input | 1 | Drive enable for bus B, active high |
| oe_ba_n | input | 1 | Drive enable for bus A, active low |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A register |
| a_io | inout | WIDTH | Bus A |
| b_io | inout | WIDTH | Bus B |

## Verification
Capture and display can fall in the same cycle: a strobe edge loads a register while that same register already drives a bus in stored mode, and a captured level can be the block's own output. The bench sweeps all sixteen enable/select combinations with three data pairs. After it checks the routed levels it raises both strobes together, and at the next falling edge it compares both buses with a model that loaded each register from the bus level the model predicted for the capture edge. The hold mode is checked in the same sweep by letting go of both buses right after a cycle that preloads the keepers.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

endpackage

// File: rtl/regbus_xcvr_capture.sv
module regbus_xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d,
  output logic             fire,
  output logic [WIDTH-1:0] q
);

  logic strobe_q;

  assign fire = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (fire) q <= d;
    end
  end

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    fire |=> (q == $past(d))); // R5

  AST_NO_SPURIOUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(q)); // R6

endmodule

// File: rtl/regbus_xcvr_keeper.sv
module regbus_xcvr_keeper #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (upd) q <= d;
  end

  AST_KEEPER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q)); // R8

endmodule

// File: rtl/regbus_xcvr_route.sv
module regbus_xcvr_route
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_pin,
  input  logic [WIDTH-1:0] b_pin,
  input  logic [WIDTH-1:0] reg_ab,
  input  logic [WIDTH-1:0] reg_ba,
  input  logic [WIDTH-1:0] keep_a,
  input  logic [WIDTH-1:0] keep_b,
  output logic             a_en,
  output logic             b_en,
  output logic             hold,
  output logic [WIDTH-1:0] a_val,
  output logic [WIDTH-1:0] b_val,
  output logic [WIDTH-1:0] a_seen,
  output logic [WIDTH-1:0] b_seen
);

  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  src_e        src_b, src_a;
  logic [WIDTH-1:0] b_stored, a_stored;
  logic [WIDTH-1:0] b_far_level, a_far_level;

  always_comb begin
    src_b = src_e'(sel_ab);
    src_a = src_e'(sel_ba);
    a_en  = ~oe_ba_n;
    b_en  = oe_ab;
    hold  = a_en & b_en & (src_a == SRC_LIVE) & (src_b == SRC_LIVE);

    b_stored = reg_ab ^ POL_MASK;
    a_stored = reg_ba ^ POL_MASK;

    // Outside the hold mode the far bus is never live from this side.
    a_far_level = b_en ? b_stored : b_pin;
    b_far_level = a_en ? a_stored : a_pin;

    if (hold) begin
      a_val = keep_a;
      b_val = keep_b;
    end else begin
      a_val = (src_a == SRC_STORED) ? a_stored : (a_far_level ^ POL_MASK);
      b_val = (src_b == SRC_STORED) ? b_stored : (b_far_level ^ POL_MASK);
    end

    a_seen = a_en ? a_val : a_pin;
    b_seen = b_en ? b_val : b_pin;
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  inout  wire  [WIDTH-1:0] a_io,
  inout  wire  [WIDTH-1:0] b_io
);

  logic             a_en, b_en, hold;
  logic             fire_ab, fire_ba;
  logic [WIDTH-1:0] a_val, b_val, a_seen, b_seen;
  logic [WIDTH-1:0] reg_ab, reg_ba, keep_a, keep_b;

  regbus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_ab (
    .clk(clk), .rst(rst), .strobe(cap_ab), .d(a_seen), .fire(fire_ab), .q(reg_ab)
  );

  regbus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_ba (
    .clk(clk), .rst(rst), .strobe(cap_ba), .d(b_seen), .fire(fire_ba), .q(reg_ba)
  );

  regbus_xcvr_keeper #(.WIDTH(WIDTH)) u_keep_a (
    .clk(clk), .rst(rst), .upd(~hold), .d(a_seen), .q(keep_a)
  );

  regbus_xcvr_keeper #(.WIDTH(WIDTH)) u_keep_b (
    .clk(clk), .rst(rst), .upd(~hold), .d(b_seen), .q(keep_b)
  );

  regbus_xcvr_route #(.WIDTH(WIDTH), .INVERT(INVERT)) u_route (
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_pin(a_io), .b_pin(b_io), .reg_ab(reg_ab), .reg_ba(reg_ba),
    .keep_a(keep_a), .keep_b(keep_b),
    .a_en(a_en), .b_en(b_en), .hold(hold),
    .a_val(a_val), .b_val(b_val), .a_seen(a_seen), .b_seen(b_seen)
  );

  assign a_io = a_en ? a_val : {WIDTH{1'bz}};
  assign b_io = b_en ? b_val : {WIDTH{1'bz}};

  AST_HOLD_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> (a_val == $past(a_val))); // R8

  AST_HOLD_KEEPS_B: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> (b_val == $past(b_val))); // R8

  AST_STORED_STEADY_B: assert property (@(posedge clk) disable iff (rst)
    (oe_ab && sel_ab && !hold && $past(oe_ab && sel_ab && !hold) && !$past(fire_ab))
      |-> $stable(b_val)); // R4

  AST_STORED_STEADY_A: assert property (@(posedge clk) disable iff (rst)
    (!oe_ba_n && sel_ba && !hold && $past(!oe_ba_n && sel_ba && !hold) && !$past(fire_ba))
      |-> $stable(a_val)); // R4

endmodule

// File: tb/tb_regbus_xcvr.sv
`timescale 1ns/1ps
module tb_regbus_xcvr;

  localparam int W = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_ab = 1'b0, cap_ba = 1'b0;
  logic oe_ab = 1'b1, oe_ba_n = 1'b0, sel_ab = 1'b1, sel_ba = 1'b1;
  logic tb_a_en = 1'b0, tb_b_en = 1'b0;
  logic [W-1:0] tb_a = '0, tb_b = '0;
  wire  [W-1:0] a0, b0, a1, b1;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_rab [2];
  logic [W-1:0] m_rba [2];
  logic [W-1:0] m_ka  [2];
  logic [W-1:0] m_kb  [2];

  always #4 clk = ~clk;

  assign a0 = tb_a_en ? tb_a : {W{1'bz}};
  assign a1 = tb_a_en ? tb_a : {W{1'bz}};
  assign b0 = tb_b_en ? tb_b : {W{1'bz}};
  assign b1 = tb_b_en ? tb_b : {W{1'bz}};

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut (
    .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_io(a0), .b_io(b0)
  );

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv (
    .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_io(a1), .b_io(b1)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pol(input int inv, input logic [W-1:0] x);
    return (inv != 0) ? ~x : x;
  endfunction

  // Expected bus levels from the requirements for one instance.
  task automatic expect_levels(input int d, input logic [W-1:0] da, input logic [W-1:0] db,
                               output logic [W-1:0] ea, output logic [W-1:0] eb);
    logic drv_a, drv_b, hold_m;
    logic [W-1:0] a_st, b_st;
    drv_a  = !oe_ba_n;
    drv_b  = oe_ab;
    hold_m = drv_a && drv_b && !sel_ab && !sel_ba;
    a_st   = pol(d, m_rba[d]);
    b_st   = pol(d, m_rab[d]);
    if (hold_m) begin
      ea = m_ka[d];
      eb = m_kb[d];
    end else begin
      eb = drv_b ? (sel_ab ? b_st : pol(d, drv_a ? a_st : da)) : db;
      ea = drv_a ? (sel_ba ? a_st : pol(d, drv_b ? b_st : db)) : da;
    end
  endtask

  function automatic string tag_for(input int d);
    logic drv_a, drv_b;
    drv_a = !oe_ba_n;
    drv_b = oe_ab;
    if (drv_a && drv_b && !sel_ab && !sel_ba) return "R8";
    if (drv_a && drv_b && sel_ab && sel_ba)   return "R7";
    if (!drv_a && !drv_b)                     return "R2";
    if (d == 1)                               return "R9";
    if ((drv_a && sel_ba) || (drv_b && sel_ab)) return "R4";
    return "R3";
  endfunction

  task automatic check_both(input string req_override, input logic [W-1:0] da,
                            input logic [W-1:0] db);
    logic [W-1:0] ea, eb;
    string t;
    for (int d = 0; d < 2; d++) begin
      expect_levels(d, da, db, ea, eb);
      t = (req_override.len() != 0) ? req_override : tag_for(d);
      check(t, (d == 0) ? "bus A true" : "bus A inverted", (d == 0) ? a0 : a1, ea);
      check(t, (d == 0) ? "bus B true" : "bus B inverted", (d == 0) ? b0 : b1, eb);
    end
  endtask

  task automatic run_combo(input logic oab, input logic obn, input logic sab, input logic sba,
                           input logic [W-1:0] da, input logic [W-1:0] db);
    logic [W-1:0] ea [2];
    logic [W-1:0] eb [2];
    // Preload keepers: both buses driven externally, block drives nothing.
    @(negedge clk);
    oe_ab = 1'b0; oe_ba_n = 1'b1; cap_ab = 1'b0; cap_ba = 1'b0;
    tb_a_en = 1'b1; tb_b_en = 1'b1; tb_a = da; tb_b = db;
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      m_ka[d] = da;
      m_kb[d] = db;
    end
    @(negedge clk);
    oe_ab = oab; oe_ba_n = obn; sel_ab = sab; sel_ba = sba;
    tb_a_en = obn; tb_b_en = !oab;
    #1;
    check_both("", da, db);                   // R2 R3 R4 R7 R8 R9
    for (int d = 0; d < 2; d++) expect_levels(d, da, db, ea[d], eb[d]);
    // Capture both directions in this very configuration.
    cap_ab = 1'b1; cap_ba = 1'b1;
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      m_rab[d] = ea[d];                       // R5: loads the A level
      m_rba[d] = eb[d];                       // R5: loads the B level
    end
    @(negedge clk);
    cap_ab = 1'b0; cap_ba = 1'b0;
    #1;
    check_both("R10", da, db);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_rab[d] = '0; m_rba[d] = '0; m_ka[d] = '0; m_kb[d] = '0;
    end
    // R1: reset state, both directions showing stored data.
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "A after reset true", a0, '0);
    check("R1", "B after reset true", b0, '0);
    check("R1", "A after reset inverted", a1, ONES);
    check("R1", "B after reset inverted", b1, ONES);

    // Full sweep of enables and selects over three data pairs.
    for (int p = 0; p < 3; p++) begin
      logic [W-1:0] da, db;
      da = (p == 0) ? 4'h3 : (p == 1) ? 4'hA : 4'hF;
      db = (p == 0) ? 4'hC : (p == 1) ? 4'h5 : 4'h0;
      for (int c = 0; c < 16; c++) begin
        run_combo(c[3], c[2], c[1], c[0], da, db);
      end
    end

    // R6: a strobe held high does not reload; a fresh rise does (R5).
    @(negedge clk);
    oe_ab = 1'b1; sel_ab = 1'b1; oe_ba_n = 1'b1; sel_ba = 1'b0;
    tb_a_en = 1'b1; tb_b_en = 1'b0; tb_a = 4'h5; cap_ab = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tb_a = 4'h9;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R6", "B with strobe held true", b0, 4'h5);
    check("R6", "B with strobe held inverted", b1, ~4'h5);
    cap_ab = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R6", "B with strobe low true", b0, 4'h5);
    cap_ab = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R5", "B after fresh rise true", b0, 4'h9);
    check("R5", "B after fresh rise inverted", b1, ~4'h9);
    cap_ab = 1'b0;

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule